// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block gives two independent ports a set of eight hardware claim flags that live apart from any shared memory. Software on either side uses a flag to take exclusive use of a shared resource. A port claims a flag by writing a zero bit and then reads the flag back. A read of zero means the port holds the flag. A read of one means the other side holds it. The holder gives the flag up by writing a one.

Each flag also remembers a claim that the non-holding port made while the flag was taken. When the holder releases the flag, ownership passes straight to the waiting port in the same update, so the waiting port never has to race for it. If the waiting port changes its mind, it withdraws its claim by writing a one. Each port selects a flag with its own active-low select and a 3-bit index. The direction of an access comes from a read/write line (low means write) together with an active-low output enable.

All updates take effect on the rising clock edge. Read data is a combinational view of the state left by the previous edges.

Top module: `semaphoreBank`

## Requirements
- R1: After reset every flag is free and no claim is waiting, so a read at any of the eight indices returns 1 on both ports.
- R2: A write of data bit 0 to a free flag makes the writing port its holder. From the next cycle that port reads 0 at that index and the other port reads 1. The two ports never both read 0 at the same index.
- R3: A write of data bit 1 by the holder, with no claim waiting, frees the flag, and both ports then read 1.
- R4: A write of 0 by the non-holding port to a taken flag is recorded as waiting. When the holder writes 1, the waiting port becomes the holder in that same update and reads 0 from the next cycle.
- R5: A write of 1 by the non-holding port withdraws its waiting claim, so a later release by the holder leaves the flag free.
- R6: Only the holder can change a taken flag. A write of 1 by a non-holder with no waiting claim has no effect, a write of 0 by the holder has no effect, and the holder keeps reading 0 until it writes 1.
- R7: If both ports write 0 to the same free flag at the same edge, the left port becomes the holder and the right port's claim is recorded as waiting.
- R8: When both ports write the same flag at the same edge, the left port's write is applied first and the right port's write is then applied to the result. For example, a left release together with a right claim leaves the right port holding the flag.
- R9: The 3-bit index selects one of eight flags, and an access to one flag leaves the other seven unchanged.
- R10: A write needs select low and read/write low at the edge. A read is active while select is low, read/write is high and output enable is low. With the select high, nothing changes. Whenever no read is active, the read bit is 1.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| lSemN | input | 1 | Left flag select, active low |
| lRwN | input | 1 | Left direction: 0 write, 1 read |
| lOeN | input | 1 | Left output enable, active low |
| lIdx | input | SEM_ADDR_W | Left flag index |
| lWrBit | input | 1 | Left write bit: 0 claim, 1 release or withdraw |
| lRdBit | output | 1 | Left read bit: 0 held by left, 1 otherwise |
| rSemN | input | 1 | Right flag select, active low |
| rRwN | input | 1 | Right direction: 0 write, 1 read |
| rOeN | input | 1 | Right output enable, active low |
| rIdx | input | SEM_ADDR_W | Right flag index |
| rWrBit | input | 1 | Right write bit: 0 claim, 1 release or withdraw |
| rRdBit | output | 1 | Right read bit: 0 held by right, 1 otherwise |

## Verification
The assertions assume the port controls are known and steady across each rising edge. They also assume that a port which reads zero in one cycle makes no write at the edge before its next read, because a read and a write cannot happen in the same cycle on one port. The stimulus changes every control on the falling edge only, and it drives a port either as a reader or as a writer in any one cycle. In that way it keeps within both assumptions, including during the random phase, where each port picks an idle, read or write slot independently.

// File: rtl/semBankPkg.sv
`timescale 1ns/1ps
package semBankPkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } semOwner_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CLAIM = 2'd1,
    OP_DROP  = 2'd2
  } semOp_e;

  // One flag: current holder plus a claim waiting from the non-holder
  typedef struct packed {
    semOwner_e owner;
    logic      waiting;
  } semLatch_t;

  typedef struct packed {
    semOp_e op;
    logic   rdEn;
  } portStrobe_t;

  typedef struct packed {
    portStrobe_t left;
    portStrobe_t right;
  } bankStrobe_t;

  localparam semLatch_t LATCH_FREE = '{owner: OWN_NONE, waiting: 1'b0};

  // Effect of one port's operation on one flag
  function automatic semLatch_t applyOp(semLatch_t cur, semOp_e op, semOwner_e me);
    semLatch_t nxt;
    semOwner_e other;
    nxt   = cur;
    other = (me == OWN_LEFT) ? OWN_RIGHT : OWN_LEFT;
    case (op)
      OP_CLAIM: begin
        if (cur.owner == OWN_NONE) begin
          nxt.owner   = me;
          nxt.waiting = 1'b0;
        end else if (cur.owner == other) begin
          nxt.waiting = 1'b1;
        end
      end
      OP_DROP: begin
        if (cur.owner == me) begin
          nxt.owner   = cur.waiting ? other : OWN_NONE;
          nxt.waiting = 1'b0;
        end else if (cur.owner == other) begin
          nxt.waiting = 1'b0;
        end
      end
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/semCtrl.sv
`timescale 1ns/1ps
module semCtrl
  import semBankPkg::*;
(
  input  logic        lSemN,
  input  logic        lRwN,
  input  logic        lOeN,
  input  logic        lWrBit,
  input  logic        rSemN,
  input  logic        rRwN,
  input  logic        rOeN,
  input  logic        rWrBit,
  output bankStrobe_t strobes
);

  function automatic portStrobe_t decodePort(logic semN, logic rwN, logic oeN, logic wrBit);
    portStrobe_t s;
    s.rdEn = !semN && rwN && !oeN;
    if (!semN && !rwN) s.op = wrBit ? OP_DROP : OP_CLAIM;
    else               s.op = OP_NONE;
    return s;
  endfunction

  always_comb begin
    strobes.left  = decodePort(lSemN, lRwN, lOeN, lWrBit);
    strobes.right = decodePort(rSemN, rRwN, rOeN, rWrBit);
  end

endmodule

// File: rtl/semDatapath.sv
`timescale 1ns/1ps
module semDatapath
  import semBankPkg::*;
#(
  parameter int SEM_ADDR_W = 3,
  localparam int NUM_SEM   = 1 << SEM_ADDR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStrobe_t           strobes,
  input  logic [SEM_ADDR_W-1:0] lIdx,
  input  logic [SEM_ADDR_W-1:0] rIdx,
  output logic                  lRdBit,
  output logic                  rRdBit
);

  logic [NUM_SEM-1:0] heldLeft;
  logic [NUM_SEM-1:0] heldRight;

  for (genvar g = 0; g < NUM_SEM; g++) begin : gLatch
    semLatch_t stateQ;
    semLatch_t afterLeft;
    semLatch_t stateD;
    semOp_e    leftOp;
    semOp_e    rightOp;

    always_comb begin
      leftOp    = (lIdx == SEM_ADDR_W'(g)) ? strobes.left.op  : OP_NONE;
      rightOp   = (rIdx == SEM_ADDR_W'(g)) ? strobes.right.op : OP_NONE;
      // left write resolved first, right write sees its result
      afterLeft = applyOp(stateQ, leftOp, OWN_LEFT);
      stateD    = applyOp(afterLeft, rightOp, OWN_RIGHT);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stateQ <= LATCH_FREE;
      else       stateQ <= stateD;
    end

    assign heldLeft[g]  = (stateQ.owner == OWN_LEFT);
    assign heldRight[g] = (stateQ.owner == OWN_RIGHT);
  end

  assign lRdBit = ~(strobes.left.rdEn  & heldLeft[lIdx]);
  assign rRdBit = ~(strobes.right.rdEn & heldRight[rIdx]);

endmodule

// File: rtl/semaphoreBank.sv
`timescale 1ns/1ps
module semaphoreBank
  import semBankPkg::*;
#(
  parameter int SEM_ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lSemN,
  input  logic                  lRwN,
  input  logic                  lOeN,
  input  logic [SEM_ADDR_W-1:0] lIdx,
  input  logic                  lWrBit,
  output logic                  lRdBit,
  input  logic                  rSemN,
  input  logic                  rRwN,
  input  logic                  rOeN,
  input  logic [SEM_ADDR_W-1:0] rIdx,
  input  logic                  rWrBit,
  output logic                  rRdBit
);

  bankStrobe_t strobes;

  semCtrl i_ctrl (
    .lSemN  (lSemN),
    .lRwN   (lRwN),
    .lOeN   (lOeN),
    .lWrBit (lWrBit),
    .rSemN  (rSemN),
    .rRwN   (rRwN),
    .rOeN   (rOeN),
    .rWrBit (rWrBit),
    .strobes(strobes)
  );

  semDatapath #(.SEM_ADDR_W(SEM_ADDR_W)) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .lIdx   (lIdx),
    .rIdx   (rIdx),
    .lRdBit (lRdBit),
    .rRdBit (rRdBit)
  );

endmodule

// File: rtl/semBankChecker.sv
`timescale 1ns/1ps
module semBankChecker #(
  parameter int SEM_ADDR_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  lSemN,
  input logic                  lRwN,
  input logic                  lOeN,
  input logic [SEM_ADDR_W-1:0] lIdx,
  input logic                  lRdBit,
  input logic                  rSemN,
  input logic                  rRwN,
  input logic                  rOeN,
  input logic [SEM_ADDR_W-1:0] rIdx,
  input logic                  rRdBit
);

  logic lReading;
  logic rReading;
  assign lReading = !lSemN && lRwN && !lOeN;
  assign rReading = !rSemN && rRwN && !rOeN;

  // R1: first cycle out of reset, every flag reads free
  p_reset_free_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!rstN) && lReading) |-> lRdBit);

  // R2: no index can be held by both ports
  p_single_owner_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lReading && rReading && lIdx == rIdx) |-> (lRdBit || rRdBit));

  // R6: a left holder stays holder while it only reads
  p_holds_left_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lReading && !lRdBit) && lReading && lIdx == $past(lIdx)) |-> !lRdBit);

  // R6: same for the right port
  p_holds_right_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rReading && !rRdBit) && rReading && rIdx == $past(rIdx)) |-> !rRdBit);

  // R10: read bits idle high when no read is active
  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!lReading |-> lRdBit) and (!rReading |-> rRdBit));

endmodule

bind semaphoreBank semBankChecker #(.SEM_ADDR_W(SEM_ADDR_W)) i_checker (
  .clk   (clk),
  .rstN  (rstN),
  .lSemN (lSemN),
  .lRwN  (lRwN),
  .lOeN  (lOeN),
  .lIdx  (lIdx),
  .lRdBit(lRdBit),
  .rSemN (rSemN),
  .rRwN  (rRwN),
  .rOeN  (rOeN),
  .rIdx  (rIdx),
  .rRdBit(rRdBit)
);

// File: tb/test_semaphoreBank.sv
`timescale 1ns/1ps
module test_semaphoreBank;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lSemN = 1'b1, lRwN = 1'b1, lOeN = 1'b1, lWrBit = 1'b1;
  logic       rSemN = 1'b1, rRwN = 1'b1, rOeN = 1'b1, rWrBit = 1'b1;
  logic [2:0] lIdx = '0, rIdx = '0;
  logic       lRdBit, rRdBit;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference: 0 free, 1 left, 2 right; pend = claim waiting from non-holder
  int owner [8];
  bit pend  [8];

  // slot kinds: 0 idle, 1 write, 2 read, 3 read with output enable high,
  // 4 write attempt with select high
  localparam int K_IDLE = 0, K_WR = 1, K_RD = 2, K_RDOFF = 3, K_NOSEL = 4;

  always #10 clk = ~clk;

  semaphoreBank i_semaphoreBank (
    .clk(clk), .rstN(rstN),
    .lSemN(lSemN), .lRwN(lRwN), .lOeN(lOeN), .lIdx(lIdx), .lWrBit(lWrBit), .lRdBit(lRdBit),
    .rSemN(rSemN), .rRwN(rRwN), .rOeN(rOeN), .rIdx(rIdx), .rWrBit(rWrBit), .rRdBit(rRdBit)
  );

  function automatic void modelOp(int a, int bitv, int me);
    int other;
    other = (me == 1) ? 2 : 1;
    if (bitv == 0) begin
      if (owner[a] == 0) begin owner[a] = me; pend[a] = 0; end
      else if (owner[a] == other) pend[a] = 1;
    end else begin
      if (owner[a] == me) begin
        owner[a] = pend[a] ? other : 0;
        pend[a]  = 0;
      end else if (owner[a] == other) pend[a] = 0;
    end
  endfunction

  task automatic check(string tag, string side, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s read bit actual=%0b expected=%0b", tag, side, act, exp);
    end
  endtask

  task automatic step(int lk, int la, int lb, int rk, int ra, int rb, string tag);
    logic eL, eR;
    @(negedge clk);
    lSemN  = !(lk == K_WR || lk == K_RD || lk == K_RDOFF);
    lRwN   = !(lk == K_WR || lk == K_NOSEL);
    lOeN   = !(lk == K_RD);
    lIdx   = la[2:0];
    lWrBit = lb[0];
    rSemN  = !(rk == K_WR || rk == K_RD || rk == K_RDOFF);
    rRwN   = !(rk == K_WR || rk == K_NOSEL);
    rOeN   = !(rk == K_RD);
    rIdx   = ra[2:0];
    rWrBit = rb[0];
    #2;
    eL = !(lk == K_RD && owner[la] == 1);
    eR = !(rk == K_RD && owner[ra] == 2);
    check(tag, "left", lRdBit, eL);
    check(tag, "right", rRdBit, eR);
    @(posedge clk);
    if (lk == K_WR) modelOp(la, lb, 1);
    if (rk == K_WR) modelOp(ra, rb, 2);
  endtask

  task automatic readBoth(int a, string tag);
    step(K_RD, a, 0, K_RD, a, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin owner[i] = 0; pend[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: all free after reset
    for (int a = 0; a < 8; a++) readBoth(a, "R1");

    // R2: left claims flag 2
    step(K_WR, 2, 0, K_IDLE, 0, 0, "R2");
    readBoth(2, "R2");
    // R9: neighbours untouched, right claims flag 3 independently
    readBoth(1, "R9");
    readBoth(3, "R9");
    step(K_IDLE, 0, 0, K_WR, 3, 0, "R9");
    step(K_RD, 2, 0, K_RD, 3, 0, "R9");

    // R6: non-holder release and holder re-claim change nothing
    step(K_WR, 2, 0, K_WR, 2, 1, "R6");
    readBoth(2, "R6");
    readBoth(2, "R6");

    // R4: right waits on flag 2, then takes it on left release
    step(K_IDLE, 0, 0, K_WR, 2, 0, "R4");
    readBoth(2, "R4");
    step(K_WR, 2, 1, K_IDLE, 0, 0, "R4");
    readBoth(2, "R4");

    // R5: left waits then withdraws; right release leaves it free
    step(K_WR, 2, 0, K_IDLE, 0, 0, "R5");
    step(K_WR, 2, 1, K_IDLE, 0, 0, "R5");
    step(K_IDLE, 0, 0, K_WR, 2, 1, "R5");
    readBoth(2, "R5");

    // R3: plain release
    step(K_IDLE, 0, 0, K_WR, 3, 1, "R3");
    readBoth(3, "R3");

    // R7: simultaneous claim on free flag 6
    step(K_WR, 6, 0, K_WR, 6, 0, "R7");
    readBoth(6, "R7");
    step(K_WR, 6, 1, K_IDLE, 0, 0, "R7");
    readBoth(6, "R7");

    // R8: right holds 6; right release with left claim -> left holds
    step(K_WR, 6, 0, K_WR, 6, 1, "R8");
    readBoth(6, "R8");
    // R8: left holds 6; left release with right claim -> right holds
    step(K_WR, 6, 1, K_WR, 6, 0, "R8");
    readBoth(6, "R8");

    // R10: select high blocks writes; output enable high hides reads
    step(K_NOSEL, 5, 0, K_NOSEL, 5, 0, "R10");
    readBoth(5, "R10");
    step(K_RDOFF, 6, 0, K_RDOFF, 6, 0, "R10");
    step(K_RD, 6, 0, K_RD, 6, 0, "R10");

    // mixed traffic against the reference
    for (int n = 0; n < 600; n++) begin
      int lk, rk;
      lk = $urandom_range(0, 4);
      rk = $urandom_range(0, 4);
      step(lk, $urandom_range(0, 7), $urandom_range(0, 1),
           rk, $urandom_range(0, 7), $urandom_range(0, 1), "R8");
    end
    for (int a = 0; a < 8; a++) readBoth(a, "R9");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule